// File: doc/BRIEF.md
# SMBus Target Transaction Sequencer

This block follows an SMBus transaction from the target's side. An I2C target front end that has already handled the bit level and matched the address sends it single-cycle event strobes: a start with the write direction, a start with the read direction, a stop, a master NACK, a received byte, and a request for the next byte to transmit. From these strobes the sequencer tracks the transaction phase and collects the written bytes in a buffer. It then raises one of three application callbacks:

- a quick command, carrying its direction bit;
- a write commit, giving the buffer and its length;
- a read fetch, which returns one byte from the application.

It also flags protocol misuse.

The first buffered byte is the SMBus command code. A repeated start with the read direction commits the buffered write before the read phase begins. A transaction that carries no data bytes ends as a quick command. Any illegal event sends the sequencer to an error phase. That phase ignores everything until the next stop.

Top module: `smbus_txn_seq`

## Requirements
- R1: After reset `phase` is 0 (idle) and every pulse output is low.
- R2: A write start in idle moves `phase` to 1 (write-data). A write start in read-data (2) or done (3) moves `phase` to 4 (error) and pulses `err_proto`.
- R3: A read start in idle moves `phase` to 2. In write-data with no buffered bytes it moves to 4 and pulses `err_proto`. In write-data with bytes buffered it commits the write and then moves to 2.
- R4: A stop with no buffered bytes pulses `quick_valid` when the phase was 1 or 2. `quick_dir` is 0 when the phase was 1 and 1 when it was 2. A stop in any other phase issues no quick command.
- R5: A stop in write-data with bytes buffered pulses `commit_valid`. It presents `commit_len` and `commit_data`, with byte i at bits [8i+7:8i]. Byte 0 is the command code.
- R6: A stop in read-data with bytes still counted pulses `err_rd_stop`. Every stop returns `phase` to 0 and empties the buffer.
- R7: A NACK in read-data moves `phase` to 3. A NACK in done changes nothing. A NACK in idle or write-data moves to 4 and pulses `err_proto`.
- R8: A read request in read-data pulses `app_fetch` in the same cycle. It then returns `app_rd_data` on `rd_data` with `rd_valid`, or 0xFF if `app_rd_en` is low. A read request in idle, write-data or done returns 0xFF, moves to 4 and pulses `err_proto`.
- R9: Bytes received in write-data are stored in arrival order. Once DEPTH bytes are held, further bytes are dropped and `err_ovf` pulses. The committed length never exceeds DEPTH.
- R10: A byte received outside write-data is not stored, as the length of a later commit shows, and it pulses `err_stray`.
- R11: The error phase is left only by a stop. Write starts, read starts, NACKs and read requests there cause no phase change, no `err_proto` pulse and no callback. A read request there still returns 0xFF.
- R12: Every result output is a registered one-cycle pulse, raised in the cycle after the event. A cycle with no event raises none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start_wr | input | 1 | Start with write direction |
| ev_start_rd | input | 1 | Start with read direction |
| ev_stop | input | 1 | Stop condition |
| ev_nack | input | 1 | Master NACK after a read byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| ev_rd_req | input | 1 | Request for the next byte to send |
| app_rd_en | input | 1 | Application read response enabled |
| app_rd_data | input | 8 | Application byte, valid while app_fetch is high |
| app_fetch | output | 1 | Combinational fetch strobe to the application |
| rd_valid | output | 1 | Byte to send is valid |
| rd_data | output | 8 | Byte to send |
| quick_valid | output | 1 | Quick command pulse |
| quick_dir | output | 1 | Quick command direction, 1 = read |
| commit_valid | output | 1 | Write commit pulse |
| commit_len | output | $clog2(DEPTH+1) | Committed byte count |
| commit_data | output | DEPTH*8 | Buffer contents |
| err_proto | output | 1 | Illegal event, error phase entered |
| err_ovf | output | 1 | Byte dropped, buffer full |
| err_stray | output | 1 | Byte received outside write-data |
| err_rd_stop | output | 1 | Stop during read with bytes counted |
| phase | output | 3 | Phase code: 0 idle, 1 write, 2 read, 3 done, 4 error |

## Verification
A wrong phase shows on `phase` in the cycle after the event that caused it. It also shows, one cycle after the next event, as a missing or spurious callback or error pulse. A wrong byte count or a bad buffer write stays hidden until the next stop or read start. At that point it appears as a wrong `commit_len`, wrong `commit_data`, a quick command instead of a commit, or the reverse. For that reason the stimulus ends transactions often and mixes write-then-read sequences with stray events.

// File: rtl/smbus_seq_pkg.sv
package smbus_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_WRITE = 3'd1,
        PH_READ  = 3'd2,
        PH_DONE  = 3'd3,
        PH_ERR   = 3'd4
    } phase_e;

    // One-cycle actions decided by the phase machine for the current event
    typedef struct packed {
        logic store;
        logic clear;
        logic commit;
        logic quick;
        logic quick_dir;
        logic fetch;
        logic err_proto;
        logic err_ovf;
        logic err_stray;
        logic err_rd_stop;
    } action_t;

endpackage

// File: rtl/smbus_seq_buf.sv
module smbus_seq_buf #(
    parameter int DEPTH = 34,
    parameter int BW    = 8,
    localparam int LEN_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   store,
    input  logic                   clear,
    input  logic [BW-1:0]          byte_in,
    output logic [LEN_W-1:0]       len,
    output logic                   full,
    output logic [DEPTH*BW-1:0]    data
);

    typedef struct packed {
        logic [LEN_W-1:0]             len;
        logic [DEPTH-1:0][BW-1:0]     mem;
    } buf_state_t;

    buf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.len = '0;
        end else if (store && !full) begin
            st_d.mem[st_q.len[IDX_W-1:0]] = byte_in;
            st_d.len = st_q.len + LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign len  = st_q.len;
    assign full = (st_q.len == LEN_W'(DEPTH));
    assign data = st_q.mem;

endmodule

// File: rtl/smbus_seq_fsm.sv
module smbus_seq_fsm
    import smbus_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ev_start_wr,
    input  logic    ev_start_rd,
    input  logic    ev_stop,
    input  logic    ev_nack,
    input  logic    ev_rd_req,
    input  logic    rx_valid,
    input  logic    len_zero,
    input  logic    buf_full,
    output phase_e  phase,
    output action_t act
);

    phase_e ph_d, ph_q;

    always_comb begin
        ph_d = ph_q;
        act  = '0;
        if (ev_start_wr) begin
            if (ph_q == PH_IDLE) begin
                ph_d = PH_WRITE;
            end else if (ph_q != PH_ERR) begin
                ph_d = PH_ERR;
                act.err_proto = 1'b1;
            end
        end else if (ev_start_rd) begin
            unique case (ph_q)
                PH_IDLE: ph_d = PH_READ;
                PH_WRITE: begin
                    if (len_zero) begin
                        ph_d = PH_ERR;
                        act.err_proto = 1'b1;
                    end else begin
                        act.commit = 1'b1;
                        ph_d = PH_READ;
                    end
                end
                PH_ERR: ph_d = PH_ERR;
                default: begin
                    ph_d = PH_ERR;
                    act.err_proto = 1'b1;
                end
            endcase
        end else if (ev_stop) begin
            ph_d      = PH_IDLE;
            act.clear = 1'b1;
            if (len_zero) begin
                act.quick     = (ph_q == PH_WRITE) || (ph_q == PH_READ);
                act.quick_dir = (ph_q == PH_READ);
            end else begin
                act.commit      = (ph_q == PH_WRITE);
                act.err_rd_stop = (ph_q == PH_READ);
            end
        end else if (ev_nack) begin
            unique case (ph_q)
                PH_READ: ph_d = PH_DONE;
                PH_DONE, PH_ERR: ph_d = ph_q;
                default: begin
                    ph_d = PH_ERR;
                    act.err_proto = 1'b1;
                end
            endcase
        end else if (ev_rd_req) begin
            unique case (ph_q)
                PH_READ: act.fetch = 1'b1;
                PH_ERR:  ph_d = PH_ERR;
                default: begin
                    ph_d = PH_ERR;
                    act.err_proto = 1'b1;
                end
            endcase
        end else if (rx_valid) begin
            if (ph_q == PH_WRITE) begin
                if (buf_full) act.err_ovf = 1'b1;
                else          act.store   = 1'b1;
            end else begin
                act.err_stray = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    assign phase = ph_q;

endmodule

// File: rtl/smbus_txn_seq.sv
module smbus_txn_seq
    import smbus_seq_pkg::*;
#(
    parameter int DEPTH = 34,
    localparam int BW    = 8,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ev_start_wr,
    input  logic                 ev_start_rd,
    input  logic                 ev_stop,
    input  logic                 ev_nack,
    input  logic                 rx_valid,
    input  logic [BW-1:0]        rx_byte,
    input  logic                 ev_rd_req,
    input  logic                 app_rd_en,
    input  logic [BW-1:0]        app_rd_data,
    output logic                 app_fetch,
    output logic                 rd_valid,
    output logic [BW-1:0]        rd_data,
    output logic                 quick_valid,
    output logic                 quick_dir,
    output logic                 commit_valid,
    output logic [LEN_W-1:0]     commit_len,
    output logic [DEPTH*BW-1:0]  commit_data,
    output logic                 err_proto,
    output logic                 err_ovf,
    output logic                 err_stray,
    output logic                 err_rd_stop,
    output logic [2:0]           phase
);

    typedef struct packed {
        logic             rd_valid;
        logic [BW-1:0]    rd_data;
        logic             quick_valid;
        logic             quick_dir;
        logic             commit_valid;
        logic [LEN_W-1:0] commit_len;
        logic             err_proto;
        logic             err_ovf;
        logic             err_stray;
        logic             err_rd_stop;
    } out_t;

    phase_e           fsm_phase;
    action_t          act;
    logic [LEN_W-1:0] buf_len;
    logic             buf_full;
    out_t             out_d, out_q;

    smbus_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev_start_wr (ev_start_wr),
        .ev_start_rd (ev_start_rd),
        .ev_stop     (ev_stop),
        .ev_nack     (ev_nack),
        .ev_rd_req   (ev_rd_req),
        .rx_valid    (rx_valid),
        .len_zero    (buf_len == '0),
        .buf_full    (buf_full),
        .phase       (fsm_phase),
        .act         (act)
    );

    smbus_seq_buf #(.DEPTH(DEPTH), .BW(BW)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .store   (act.store),
        .clear   (act.clear),
        .byte_in (rx_byte),
        .len     (buf_len),
        .full    (buf_full),
        .data    (commit_data)
    );

    always_comb begin
        out_d              = '0;
        out_d.commit_len   = out_q.commit_len;
        out_d.rd_valid     = ev_rd_req && !ev_start_wr && !ev_start_rd && !ev_stop && !ev_nack;
        out_d.rd_data      = (act.fetch && app_rd_en) ? app_rd_data : '1;
        out_d.quick_valid  = act.quick;
        out_d.quick_dir    = act.quick_dir;
        out_d.commit_valid = act.commit;
        if (act.commit) out_d.commit_len = buf_len;
        out_d.err_proto    = act.err_proto;
        out_d.err_ovf      = act.err_ovf;
        out_d.err_stray    = act.err_stray;
        out_d.err_rd_stop  = act.err_rd_stop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign app_fetch    = act.fetch;
    assign rd_valid     = out_q.rd_valid;
    assign rd_data      = out_q.rd_data;
    assign quick_valid  = out_q.quick_valid;
    assign quick_dir    = out_q.quick_dir;
    assign commit_valid = out_q.commit_valid;
    assign commit_len   = out_q.commit_len;
    assign err_proto    = out_q.err_proto;
    assign err_ovf      = out_q.err_ovf;
    assign err_stray    = out_q.err_stray;
    assign err_rd_stop  = out_q.err_rd_stop;
    assign phase        = fsm_phase;

endmodule

// File: rtl/smbus_seq_chk.sv
module smbus_seq_chk #(
    parameter int DEPTH = 34,
    localparam int LEN_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ev_start_wr,
    input logic             ev_start_rd,
    input logic             ev_stop,
    input logic             ev_nack,
    input logic             ev_rd_req,
    input logic             rd_valid,
    input logic [7:0]       rd_data,
    input logic             quick_valid,
    input logic             quick_dir,
    input logic             commit_valid,
    input logic [LEN_W-1:0] commit_len,
    input logic             err_proto,
    input logic [LEN_W-1:0] buf_len,
    input logic [2:0]       phase
);

    p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (phase == 3'd0));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd4) && !ev_stop |=> (phase == 3'd4) && !err_proto);

    p_quick_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop && (phase == 3'd1) && (buf_len == '0) |=> quick_valid && !quick_dir);

    p_quick_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop && (phase == 3'd2) && (buf_len == '0) |=> quick_valid && quick_dir);

    p_commit_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_len != '0));

    p_nack_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nack && (phase == 3'd2) |=> (phase == 3'd3));

    p_rd_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rd_req && (phase != 3'd2) && !ev_start_wr && !ev_start_rd && !ev_stop && !ev_nack
        |=> rd_valid && (rd_data == 8'hFF));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        buf_len <= LEN_W'(DEPTH));

    p_one_callback_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({quick_valid, commit_valid, rd_valid}));

    p_start_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start_wr && (phase == 3'd0) |=> (phase == 3'd1));

endmodule

bind smbus_txn_seq smbus_seq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_start_wr  (ev_start_wr),
    .ev_start_rd  (ev_start_rd),
    .ev_stop      (ev_stop),
    .ev_nack      (ev_nack),
    .ev_rd_req    (ev_rd_req),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .quick_valid  (quick_valid),
    .quick_dir    (quick_dir),
    .commit_valid (commit_valid),
    .commit_len   (commit_len),
    .err_proto    (err_proto),
    .buf_len      (buf_len),
    .phase        (phase)
);

// File: tb/tb_smbus_txn_seq.sv
module tb_smbus_txn_seq;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 34;
    localparam int LEN_W      = $clog2(DEPTH + 1);

    localparam int K_SWR = 0, K_SRD = 1, K_STOP = 2, K_NACK = 3, K_REQ = 4, K_BYTE = 5, K_NONE = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start_wr = 0, ev_start_rd = 0, ev_stop = 0, ev_nack = 0, rx_valid = 0, ev_rd_req = 0;
    logic [7:0] rx_byte = 0;
    logic app_rd_en = 0;
    logic [7:0] app_rd_data = 0;
    logic app_fetch, rd_valid, quick_valid, quick_dir, commit_valid;
    logic [7:0] rd_data;
    logic [LEN_W-1:0] commit_len;
    logic [DEPTH*8-1:0] commit_data;
    logic err_proto, err_ovf, err_stray, err_rd_stop;
    logic [2:0] phase;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    int m_phase = 0;
    int m_len = 0;
    logic [7:0] m_buf [DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    smbus_txn_seq #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .ev_start_wr(ev_start_wr), .ev_start_rd(ev_start_rd), .ev_stop(ev_stop),
        .ev_nack(ev_nack), .rx_valid(rx_valid), .rx_byte(rx_byte), .ev_rd_req(ev_rd_req),
        .app_rd_en(app_rd_en), .app_rd_data(app_rd_data), .app_fetch(app_fetch),
        .rd_valid(rd_valid), .rd_data(rd_data), .quick_valid(quick_valid), .quick_dir(quick_dir),
        .commit_valid(commit_valid), .commit_len(commit_len), .commit_data(commit_data),
        .err_proto(err_proto), .err_ovf(err_ovf), .err_stray(err_stray),
        .err_rd_stop(err_rd_stop), .phase(phase)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // expected pulses per event, from the requirements
    task automatic do_event(input int kind, input logic [7:0] b, input logic en, input logic [7:0] ad);
        int e_ph, e_q, e_qd, e_c, e_cl, e_rv, e_rd, e_pr, e_ov, e_st, e_rs, e_fetch;
        string tag;
        logic [7:0] snap [DEPTH];
        e_ph = m_phase; e_q = 0; e_qd = 0; e_c = 0; e_cl = 0; e_rv = 0; e_rd = 255;
        e_pr = 0; e_ov = 0; e_st = 0; e_rs = 0; e_fetch = 0;
        tag = "R12";
        case (kind)
            K_SWR: begin tag = "R2";
                if (m_phase == 0) e_ph = 1;
                else if (m_phase != 4) begin e_ph = 4; e_pr = 1; end
            end
            K_SRD: begin tag = "R3";
                if (m_phase == 0) e_ph = 2;
                else if (m_phase == 1) begin
                    if (m_len == 0) begin e_ph = 4; e_pr = 1; end
                    else begin e_c = 1; e_cl = m_len; e_ph = 2; end
                end else if (m_phase != 4) begin e_ph = 4; e_pr = 1; end
            end
            K_STOP: begin
                tag = (m_len == 0) ? "R4" : ((m_phase == 1) ? "R5" : "R6");
                if (m_len == 0) begin
                    e_q  = (m_phase == 1 || m_phase == 2) ? 1 : 0;
                    e_qd = (m_phase == 2) ? 1 : 0;
                end else begin
                    if (m_phase == 1) begin e_c = 1; e_cl = m_len; end
                    if (m_phase == 2) e_rs = 1;
                end
                e_ph = 0;
            end
            K_NACK: begin tag = "R7";
                if (m_phase == 2) e_ph = 3;
                else if (m_phase == 0 || m_phase == 1) begin e_ph = 4; e_pr = 1; end
            end
            K_REQ: begin tag = "R8";
                e_rv = 1;
                if (m_phase == 2) begin e_fetch = 1; e_rd = en ? int'(ad) : 255; end
                else if (m_phase != 4) begin e_ph = 4; e_pr = 1; end
            end
            K_BYTE: begin
                tag = (m_phase == 1) ? "R9" : "R10";
                if (m_phase == 1) begin
                    if (m_len >= DEPTH) e_ov = 1;
                    else begin m_buf[m_len] = b; m_len++; end
                end else e_st = 1;
            end
            default: tag = "R12";
        endcase
        if (m_phase == 4 && kind != K_STOP) tag = "R11";
        for (int i = 0; i < DEPTH; i++) snap[i] = m_buf[i];
        if (kind == K_STOP) m_len = 0;
        m_phase = e_ph;

        ev_start_wr = (kind == K_SWR); ev_start_rd = (kind == K_SRD); ev_stop = (kind == K_STOP);
        ev_nack = (kind == K_NACK); ev_rd_req = (kind == K_REQ); rx_valid = (kind == K_BYTE);
        rx_byte = b; app_rd_en = en; app_rd_data = ad;
        #1;
        chk(tag, "app_fetch", int'(app_fetch), e_fetch);
        @(posedge clk);
        @(negedge clk);
        ev_start_wr = 0; ev_start_rd = 0; ev_stop = 0; ev_nack = 0; ev_rd_req = 0; rx_valid = 0;
        chk(tag, "phase", int'(phase), e_ph);
        chk(tag, "quick_valid", int'(quick_valid), e_q);
        chk(tag, "quick_dir", int'(quick_dir), e_qd);
        chk(tag, "commit_valid", int'(commit_valid), e_c);
        if (e_c == 1) begin
            chk(tag, "commit_len", int'(commit_len), e_cl);
            for (int i = 0; i < e_cl; i++)
                chk(tag, "commit_data", int'(commit_data[8*i +: 8]), int'(snap[i]));
        end
        chk(tag, "rd_valid", int'(rd_valid), e_rv);
        if (e_rv == 1) chk(tag, "rd_data", int'(rd_data), e_rd);
        chk(tag, "err_proto", int'(err_proto), e_pr);
        chk(tag, "err_ovf", int'(err_ovf), e_ov);
        chk(tag, "err_stray", int'(err_stray), e_st);
        chk(tag, "err_rd_stop", int'(err_rd_stop), e_rs);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < DEPTH; i++) m_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "phase", int'(phase), 0);
        chk("R1", "pulses", int'({quick_valid, commit_valid, rd_valid, err_proto, err_ovf, err_stray, err_rd_stop}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // write of three bytes then stop (R5)
        do_event(K_SWR, 0, 0, 0);
        do_event(K_BYTE, 8'hA5, 0, 0);
        do_event(K_BYTE, 8'h02, 0, 0);
        do_event(K_BYTE, 8'h3C, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // quick write and quick read (R4)
        do_event(K_SWR, 0, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        do_event(K_SRD, 0, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // write, repeated read start, fetches, NACK, NACK in done, stop (R3, R7, R8)
        do_event(K_SWR, 0, 0, 0);
        do_event(K_BYTE, 8'h11, 0, 0);
        do_event(K_SRD, 0, 0, 0);
        do_event(K_REQ, 0, 1, 8'h5A);
        do_event(K_REQ, 0, 0, 8'h77);
        do_event(K_NACK, 0, 0, 0);
        do_event(K_NACK, 0, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // repeated read with empty buffer -> error, absorption (R3, R11)
        do_event(K_SWR, 0, 0, 0);
        do_event(K_SRD, 0, 0, 0);
        do_event(K_SWR, 0, 0, 0);
        do_event(K_REQ, 0, 1, 8'h12);
        do_event(K_NACK, 0, 0, 0);
        do_event(K_BYTE, 8'h99, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // stop during read with bytes counted (R6)
        do_event(K_SWR, 0, 0, 0);
        do_event(K_BYTE, 8'h40, 0, 0);
        do_event(K_SRD, 0, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // stray byte in idle then commit length proves it was not stored (R10)
        do_event(K_BYTE, 8'hEE, 0, 0);
        do_event(K_SWR, 0, 0, 0);
        do_event(K_BYTE, 8'h01, 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // overflow (R9)
        do_event(K_SWR, 0, 0, 0);
        for (int i = 0; i < DEPTH + 3; i++) do_event(K_BYTE, 8'(i * 7 + 3), 0, 0);
        do_event(K_STOP, 0, 0, 0);
        // idle cycles raise nothing (R12)
        do_event(K_NONE, 0, 0, 0);
        do_event(K_NONE, 0, 0, 0);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int r, k;
            r = int'($urandom % 16);
            if (r < 2) k = K_SWR;
            else if (r < 4) k = K_SRD;
            else if (r < 6) k = K_STOP;
            else if (r < 7) k = K_NACK;
            else if (r < 9) k = K_REQ;
            else if (r < 15) k = K_BYTE;
            else k = K_NONE;
            do_event(k, 8'($urandom), 1'($urandom), 8'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

endmodule